// File: doc/BRIEF.md
# SDRAM Controller Indirect Configuration Register File

This block holds the configuration and status registers of an SDRAM controller. Software reaches them through a two-port window. It first writes an internal register offset to the address port. It then writes or reads the data port, and that access lands on the register the held offset selects. Each register applies its own write behaviour:

- some bits are masked off;
- some bits are forced high;
- error status is cleared by writing ones;
- the status register cannot be written;
- changing the enable and self-refresh bits of the configuration register updates the status register as a side effect.

The block exports three things to the rest of the controller: the controller enable bit, the four bank descriptor values for a bank decoder, and an ECC error interrupt. It generates no SDRAM commands and counts no refresh.

A small access state machine sequences reads. It has two states, `ST_IDLE` and `ST_RESP`, with these transitions:

- `ST_IDLE` to `ST_RESP` when a read is requested.
- `ST_RESP` stays in `ST_RESP` when a further read is requested.
- `ST_RESP` to `ST_IDLE` when no read is requested.

Read data is presented in `ST_RESP`.

Top module: `sdr_cfg_regfile`

## Requirements
- R1: `addr_we` loads `wr_data[7:0]` into the offset register. A data write or read request in the same cycle uses the offset held before that edge.
- R2: A read request sampled at an edge makes `rd_valid` high for the following cycle, with `rd_data` holding the selected register value. Outside that cycle `rd_valid` is low and `rd_data` is zero.
- R3: After reset the registers hold these values: refresh timing (0x30) 0x05F00000, timing (0x80) 0x00854009, power management (0x34) 0x07C00000, configuration (0x20) 0x00800000. All other registers hold zero.
- R4: Error status registers at 0x00 and 0x08 are write-one-to-clear. The stored value becomes old AND NOT data, so after reset they stay zero.
- R5: The error address register at 0x10 stores the full 32-bit data word.
- R6: Configuration register writes store the full word, and `ctrl_enable` is configuration bit 31. When bit 31 goes from 0 to 1, status bit 31 clears. When bit 31 goes from 1 to 0, status bit 31 sets. Both take effect on the next cycle.
- R7: Whenever a configuration write changes bit 30, status bit 30 takes the new value.
- R8: The status register at 0x24 is read-only, and a data write to it leaves it unchanged.
- R9: Write masks are 0x3FF80000 for refresh timing, 0x018FC01F for timing and 0x00F00000 for ECC config (0x94). Power management stores (data AND 0xF8000000) OR 0x07C00000.
- R10: Bank descriptors at 0x40, 0x44, 0x48 and 0x4C store data AND 0xFFDEE001. Bank i appears on `bank_cfg[32*i+31:32*i]`.
- R11: The ECC error status register at 0x98 stores the full word. `ecc_irq` is high from the cycle after a write that leaves it nonzero, and low from the cycle after a write of zero.
- R12: An offset not listed above reads as zero, and a write to it changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_we | input | 1 | Load offset register from wr_data |
| data_we | input | 1 | Write wr_data to the selected register |
| rd_req | input | 1 | Read the selected register |
| wr_data | input | 32 | Write data for both ports |
| rd_data | output | 32 | Read data, valid with rd_valid |
| rd_valid | output | 1 | Read response cycle |
| ctrl_enable | output | 1 | Controller enable (configuration bit 31) |
| bank_cfg | output | 128 | Four bank descriptors, bank 0 in the low word |
| ecc_irq | output | 1 | ECC error interrupt |

## Verification
Every register write, together with the effects it has on status, `ctrl_enable`, `bank_cfg` and `ecc_irq`, is visible one cycle after the edge that samples `data_we`. A read response appears exactly one cycle after the edge that samples `rd_req` and lasts only that cycle. The bench drives inputs on falling edges and samples on the next falling edge after the relevant rising edge, so each result is observed in the cycle it is due. It also checks that `rd_valid` has dropped one cycle later.

// File: rtl/sdr_cfg_pkg.sv
package sdr_cfg_pkg;
    localparam int DW = 32;

    typedef enum logic [0:0] {ST_IDLE, ST_RESP} acc_state_e;

    // Internal offsets; bank descriptors follow OFS_BANK0 at a stride of 4.
    localparam logic [7:0] OFS_ERR0    = 8'h00;
    localparam logic [7:0] OFS_ERR1    = 8'h08;
    localparam logic [7:0] OFS_ERRADDR = 8'h10;
    localparam logic [7:0] OFS_CFG     = 8'h20;
    localparam logic [7:0] OFS_STAT    = 8'h24;
    localparam logic [7:0] OFS_RFSH    = 8'h30;
    localparam logic [7:0] OFS_PWR     = 8'h34;
    localparam logic [7:0] OFS_BANK0   = 8'h40;
    localparam logic [7:0] OFS_TIMING  = 8'h80;
    localparam logic [7:0] OFS_ECCCFG  = 8'h94;
    localparam logic [7:0] OFS_ECCERR  = 8'h98;

    localparam logic [DW-1:0] MSK_RFSH   = 32'h3FF8_0000;
    localparam logic [DW-1:0] MSK_TIMING = 32'h018F_C01F;
    localparam logic [DW-1:0] MSK_ECCCFG = 32'h00F0_0000;
    localparam logic [DW-1:0] MSK_PWR    = 32'hF800_0000;
    localparam logic [DW-1:0] SET_PWR    = 32'h07C0_0000;
    localparam logic [DW-1:0] MSK_BANK   = 32'hFFDE_E001;

    localparam logic [DW-1:0] RST_RFSH   = 32'h05F0_0000;
    localparam logic [DW-1:0] RST_TIMING = 32'h0085_4009;
    localparam logic [DW-1:0] RST_PWR    = 32'h07C0_0000;
    localparam logic [DW-1:0] RST_CFG    = 32'h0080_0000;

    localparam int EN_BIT = 31;
    localparam int SR_BIT = 30;
endpackage

// File: rtl/sdr_cfg_access_fsm.sv
module sdr_cfg_access_fsm
    import sdr_cfg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rd_req,
    output logic rd_valid
);
    acc_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (rd_req) state_d = ST_RESP;
            ST_RESP: if (!rd_req) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        rd_valid = (state_q == ST_RESP);
    end
endmodule

// File: rtl/sdr_cfg_rdmux.sv
module sdr_cfg_rdmux
    import sdr_cfg_pkg::*;
#(
    parameter int OFS_W = 8,
    parameter int NBANK = 4
) (
    input  logic [OFS_W-1:0]    ofs,
    input  logic [DW-1:0]       err0,
    input  logic [DW-1:0]       err1,
    input  logic [DW-1:0]       err_addr,
    input  logic [DW-1:0]       cfg,
    input  logic [DW-1:0]       status,
    input  logic [DW-1:0]       rfsh,
    input  logic [DW-1:0]       pwr,
    input  logic [DW-1:0]       timing,
    input  logic [DW-1:0]       ecc_cfg,
    input  logic [DW-1:0]       ecc_err,
    input  logic [NBANK*DW-1:0] banks,
    output logic [DW-1:0]       value
);
    always_comb begin
        value = '0;
        if      (ofs == OFS_W'(OFS_ERR0))    value = err0;
        else if (ofs == OFS_W'(OFS_ERR1))    value = err1;
        else if (ofs == OFS_W'(OFS_ERRADDR)) value = err_addr;
        else if (ofs == OFS_W'(OFS_CFG))     value = cfg;
        else if (ofs == OFS_W'(OFS_STAT))    value = status;
        else if (ofs == OFS_W'(OFS_RFSH))    value = rfsh;
        else if (ofs == OFS_W'(OFS_PWR))     value = pwr;
        else if (ofs == OFS_W'(OFS_TIMING))  value = timing;
        else if (ofs == OFS_W'(OFS_ECCCFG))  value = ecc_cfg;
        else if (ofs == OFS_W'(OFS_ECCERR))  value = ecc_err;
        for (int i = 0; i < NBANK; i++) begin
            if (ofs == OFS_W'(int'(OFS_BANK0) + 4 * i)) value = banks[i*DW +: DW];
        end
    end
endmodule

// File: rtl/sdr_cfg_regfile.sv
module sdr_cfg_regfile
    import sdr_cfg_pkg::*;
#(
    parameter int OFS_W = 8,
    parameter int NBANK = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 addr_we,
    input  logic                 data_we,
    input  logic                 rd_req,
    input  logic [31:0]          wr_data,
    output logic [31:0]          rd_data,
    output logic                 rd_valid,
    output logic                 ctrl_enable,
    output logic [NBANK*32-1:0]  bank_cfg,
    output logic                 ecc_irq
);
    localparam int BANK_BITS = NBANK * DW;

    logic [OFS_W-1:0] ofs;
    logic [DW-1:0] err0, err1, err_addr, cfg, status, rfsh, pwr, timing, ecc_cfg, ecc_err;
    logic [BANK_BITS-1:0] banks;
    logic [DW-1:0] rd_value;

    function automatic logic hit(input logic [OFS_W-1:0] o, input logic [7:0] target);
        return o == OFS_W'(target);
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) ofs <= '0;
        else if (addr_we) ofs <= wr_data[OFS_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err0     <= '0;
            err1     <= '0;
            err_addr <= '0;
            cfg      <= RST_CFG;
            status   <= '0;
            rfsh     <= RST_RFSH;
            pwr      <= RST_PWR;
            timing   <= RST_TIMING;
            ecc_cfg  <= '0;
            ecc_err  <= '0;
        end else if (data_we) begin
            if (hit(ofs, OFS_ERR0))    err0     <= err0 & ~wr_data;
            if (hit(ofs, OFS_ERR1))    err1     <= err1 & ~wr_data;
            if (hit(ofs, OFS_ERRADDR)) err_addr <= wr_data;
            if (hit(ofs, OFS_RFSH))    rfsh     <= wr_data & MSK_RFSH;
            if (hit(ofs, OFS_PWR))     pwr      <= (wr_data & MSK_PWR) | SET_PWR;
            if (hit(ofs, OFS_TIMING))  timing   <= wr_data & MSK_TIMING;
            if (hit(ofs, OFS_ECCCFG))  ecc_cfg  <= wr_data & MSK_ECCCFG;
            if (hit(ofs, OFS_ECCERR))  ecc_err  <= wr_data;
            if (hit(ofs, OFS_CFG)) begin
                cfg <= wr_data;
                if (!cfg[EN_BIT] && wr_data[EN_BIT])      status[EN_BIT] <= 1'b0;
                else if (cfg[EN_BIT] && !wr_data[EN_BIT]) status[EN_BIT] <= 1'b1;
                if (cfg[SR_BIT] != wr_data[SR_BIT])       status[SR_BIT] <= wr_data[SR_BIT];
            end
        end
    end

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        localparam logic [OFS_W-1:0] BOFS = OFS_W'(int'(OFS_BANK0) + 4 * g);
        always_ff @(posedge clk) begin
            if (!rst_n) banks[g*DW +: DW] <= '0;
            else if (data_we && ofs == BOFS) banks[g*DW +: DW] <= wr_data & MSK_BANK;
        end
    end

    sdr_cfg_rdmux #(.OFS_W(OFS_W), .NBANK(NBANK)) u_rdmux (
        .ofs(ofs), .err0(err0), .err1(err1), .err_addr(err_addr), .cfg(cfg),
        .status(status), .rfsh(rfsh), .pwr(pwr), .timing(timing),
        .ecc_cfg(ecc_cfg), .ecc_err(ecc_err), .banks(banks), .value(rd_value)
    );

    sdr_cfg_access_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_valid(rd_valid)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)      rd_data <= '0;
        else if (rd_req) rd_data <= rd_value;
        else             rd_data <= '0;
    end

    assign ctrl_enable = cfg[EN_BIT];
    assign bank_cfg    = banks;
    assign ecc_irq     = |ecc_err;
endmodule

// File: rtl/sdr_cfg_regfile_chk.sv
module sdr_cfg_regfile_chk
    import sdr_cfg_pkg::*;
#(
    parameter int OFS_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [OFS_W-1:0] ofs,
    input logic             data_we,
    input logic             rd_req,
    input logic [31:0]      wr_data,
    input logic             rd_valid,
    input logic             ctrl_enable,
    input logic [31:0]      status,
    input logic             ecc_irq
);
    a_r2_resp_next: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rd_valid);
    a_r2_no_resp: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> !rd_valid);
    a_r8_status_ro: assert property (@(posedge clk) disable iff (!rst_n)
        (data_we && ofs == OFS_W'(OFS_STAT)) |=> $stable(status));
    a_r6_enable_on: assert property (@(posedge clk) disable iff (!rst_n)
        (data_we && ofs == OFS_W'(OFS_CFG) && !ctrl_enable && wr_data[31])
        |=> (ctrl_enable && !status[31]));
    a_r6_enable_off: assert property (@(posedge clk) disable iff (!rst_n)
        (data_we && ofs == OFS_W'(OFS_CFG) && ctrl_enable && !wr_data[31])
        |=> (!ctrl_enable && status[31]));
    a_r11_irq_set: assert property (@(posedge clk) disable iff (!rst_n)
        (data_we && ofs == OFS_W'(OFS_ECCERR) && wr_data != 32'd0) |=> ecc_irq);
    a_r11_irq_clr: assert property (@(posedge clk) disable iff (!rst_n)
        (data_we && ofs == OFS_W'(OFS_ECCERR) && wr_data == 32'd0) |=> !ecc_irq);
endmodule

bind sdr_cfg_regfile sdr_cfg_regfile_chk #(.OFS_W(OFS_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ofs(ofs), .data_we(data_we), .rd_req(rd_req),
    .wr_data(wr_data), .rd_valid(rd_valid), .ctrl_enable(ctrl_enable),
    .status(status), .ecc_irq(ecc_irq)
);

// File: tb/sdr_cfg_regfile_bench.sv
module sdr_cfg_regfile_bench;
    localparam int CLK_PERIOD = 10;

    logic clk = 0, rst_n = 0, addr_we = 0, data_we = 0, rd_req = 0;
    logic [31:0] wr_data = '0, rd_data;
    logic rd_valid, ctrl_enable, ecc_irq;
    logic [127:0] bank_cfg;
    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdr_cfg_regfile u_sdr_cfg_regfile (
        .clk(clk), .rst_n(rst_n), .addr_we(addr_we), .data_we(data_we), .rd_req(rd_req),
        .wr_data(wr_data), .rd_data(rd_data), .rd_valid(rd_valid),
        .ctrl_enable(ctrl_enable), .bank_cfg(bank_cfg), .ecc_irq(ecc_irq)
    );

    // Bench model of the register set, built from the requirements.
    logic [31:0] m_err0, m_err1, m_eaddr, m_cfg, m_stat, m_rfsh, m_pwr, m_tim, m_eccc, m_ecce;
    logic [31:0] m_bank [4];

    task automatic mdl_reset();
        m_err0 = 0; m_err1 = 0; m_eaddr = 0; m_cfg = 32'h0080_0000; m_stat = 0;
        m_rfsh = 32'h05F0_0000; m_pwr = 32'h07C0_0000; m_tim = 32'h0085_4009;
        m_eccc = 0; m_ecce = 0;
        for (int i = 0; i < 4; i++) m_bank[i] = 0;
    endtask

    function automatic logic [31:0] mdl_read(input logic [7:0] o);
        case (o)
            8'h00: return m_err0;   8'h08: return m_err1;
            8'h10: return m_eaddr;  8'h20: return m_cfg;
            8'h24: return m_stat;   8'h30: return m_rfsh;
            8'h34: return m_pwr;    8'h80: return m_tim;
            8'h94: return m_eccc;   8'h98: return m_ecce;
            8'h40: return m_bank[0]; 8'h44: return m_bank[1];
            8'h48: return m_bank[2]; 8'h4C: return m_bank[3];
            default: return 32'h0;
        endcase
    endfunction

    task automatic mdl_write(input logic [7:0] o, input logic [31:0] v);
        case (o)
            8'h00: m_err0 = m_err0 & ~v;
            8'h08: m_err1 = m_err1 & ~v;
            8'h10: m_eaddr = v;
            8'h20: begin
                if (!m_cfg[31] && v[31]) m_stat[31] = 0;
                else if (m_cfg[31] && !v[31]) m_stat[31] = 1;
                if (m_cfg[30] != v[30]) m_stat[30] = v[30];
                m_cfg = v;
            end
            8'h30: m_rfsh = v & 32'h3FF8_0000;
            8'h34: m_pwr = (v & 32'hF800_0000) | 32'h07C0_0000;
            8'h80: m_tim = v & 32'h018F_C01F;
            8'h94: m_eccc = v & 32'h00F0_0000;
            8'h98: m_ecce = v;
            8'h40, 8'h44, 8'h48, 8'h4C: m_bank[(o - 8'h40) >> 2] = v & 32'hFFDE_E001;
            default: ;
        endcase
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic set_ofs(input logic [7:0] o);
        @(negedge clk); addr_we = 1; wr_data = {24'h0, o};
        @(negedge clk); addr_we = 0;
    endtask

    task automatic wr(input logic [7:0] o, input logic [31:0] v);
        set_ofs(o);
        data_we = 1; wr_data = v;
        @(negedge clk); data_we = 0;
        mdl_write(o, v);
    endtask

    task automatic rd(input logic [7:0] o, output logic [31:0] v);
        set_ofs(o);
        rd_req = 1;
        @(negedge clk); rd_req = 0;
        n_chk++;
        if (rd_valid !== 1'b1) begin
            n_fail++;
            $display("FAIL R2 rd_valid act=%b exp=1", rd_valid);
        end
        v = rd_data;
    endtask

    task automatic check_reg(input string tag, input logic [7:0] o);
        logic [31:0] v;
        rd(o, v);
        check(tag, v, mdl_read(o));
    endtask

    task automatic check_exports(input string tag);
        check({tag, " R6 enable"}, {31'h0, ctrl_enable}, {31'h0, m_cfg[31]});
        check({tag, " R10 bank"}, bank_cfg[31:0], m_bank[0]);
        check({tag, " R10 bank"}, bank_cfg[63:32], m_bank[1]);
        check({tag, " R10 bank"}, bank_cfg[95:64], m_bank[2]);
        check({tag, " R10 bank"}, bank_cfg[127:96], m_bank[3]);
        check({tag, " R11 irq"}, {31'h0, ecc_irq}, {31'h0, (m_ecce != 0)});
    endtask

    localparam logic [7:0] IMPL [14] = '{8'h00, 8'h08, 8'h10, 8'h20, 8'h24, 8'h30, 8'h34,
                                         8'h40, 8'h44, 8'h48, 8'h4C, 8'h80, 8'h94, 8'h98};

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL R2 watchdog act=timeout exp=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] v;
        void'($urandom(32'd20240611));
        mdl_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R3: reset values of every register and of the exports
        check("R2 idle rd_valid", {31'h0, rd_valid}, 32'h0);
        check("R2 idle rd_data", rd_data, 32'h0);
        for (int i = 0; i < 14; i++) check_reg("R3 reset", IMPL[i]);
        check_exports("R3 reset");

        // R2: response lasts one cycle only
        @(negedge clk);
        check("R2 rd_valid drops", {31'h0, rd_valid}, 32'h0);
        check("R2 rd_data zero", rd_data, 32'h0);

        // R4: write-one-to-clear stays zero
        wr(8'h00, 32'hFFFF_FFFF); check_reg("R4 err0", 8'h00);
        wr(8'h08, 32'h1234_5678); check_reg("R4 err1", 8'h08);

        // R6/R7: enable and self-refresh transitions
        wr(8'h20, 32'hC000_0000); check_reg("R6 en on status", 8'h24);
        check_exports("R6 en on");
        check("R7 sr set", {31'h0, mdl_read(8'h24) == 32'h4000_0000}, 32'h1);
        wr(8'h20, 32'h0000_0000); check_reg("R6 en off status", 8'h24);
        check_exports("R6 en off");
        check("R7 sr clr", {31'h0, mdl_read(8'h24) == 32'h8000_0000}, 32'h1);

        // R8: status is read-only
        wr(8'h24, 32'h0000_0000); check_reg("R8 status ro", 8'h24);
        wr(8'h24, 32'hFFFF_FFFF); check_reg("R8 status ro", 8'h24);

        // R9: masks and forced bits with all-ones and all-zeros data
        wr(8'h34, 32'h0); check_reg("R9 pwr forced", 8'h34);
        wr(8'h34, 32'hFFFF_FFFF); check_reg("R9 pwr mask", 8'h34);
        wr(8'h30, 32'hFFFF_FFFF); check_reg("R9 rfsh mask", 8'h30);
        wr(8'h80, 32'hFFFF_FFFF); check_reg("R9 timing mask", 8'h80);
        wr(8'h94, 32'hFFFF_FFFF); check_reg("R9 ecccfg mask", 8'h94);

        // R10: bank descriptors
        wr(8'h4C, 32'hFFFF_FFFF); check_reg("R10 bank3", 8'h4C);
        check_exports("R10 bank3");

        // R11: interrupt follows ECC error status
        wr(8'h98, 32'h0000_0001); check_exports("R11 set");
        wr(8'h98, 32'h0); check_exports("R11 clr");

        // R12: unimplemented offsets read zero and disturb nothing
        wr(8'h50, 32'hFFFF_FFFF); check_reg("R12 unimpl read", 8'h50);
        wr(8'hFC, 32'hA5A5_A5A5); check_reg("R12 unimpl read", 8'hFC);
        for (int i = 0; i < 14; i++) check_reg("R12 untouched", IMPL[i]);

        // R1/R5: data write in the same cycle as an offset write uses the old offset
        set_ofs(8'h10);
        addr_we = 1; data_we = 1; wr_data = 32'h0000_0030;
        @(negedge clk); addr_we = 0; data_we = 0;
        mdl_write(8'h10, 32'h0000_0030);
        rd_req = 1;
        @(negedge clk); rd_req = 0;
        check("R1 offset now rfsh", rd_data, m_rfsh);
        check_reg("R5 erraddr", 8'h10);

        // Random mix of writes and read-backs
        for (int n = 0; n < 400; n++) begin
            logic [7:0] o;
            logic [31:0] d;
            int pick;
            pick = $urandom % 16;
            o = (pick < 14) ? IMPL[pick] : ((pick == 14) ? 8'h2C : 8'hA0);
            d = ($urandom % 4 == 0) ? 32'h0 : $urandom;
            wr(o, d);
            check_exports("R10 random");
            check_reg("R9 random", o);
            if (n % 8 == 0) check_reg("R7 random status", 8'h24);
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule